// File: doc/BRIEF.md
# Wide Register Write Broadcaster

This block is a write-only memory-mapped slave that sits between a 32-bit bus and a set of downstream frame-configuration ports whose registers are 128 bits wide. Software writes a 128-bit word as four 32-bit accesses. Word-address bits [1:0], which are byte-address bits [3:2], pick the lane. Lanes 0 to 2 are held in a shared staging buffer. The write to lane 3 completes the word. In that same write the block issues one packet that carries a 6-bit register index and all four lanes. The packet goes to every downstream port that the enable mask selects, and all of them see it in the same cycle.

Two 4 KB windows reach the block, and the `win_sel` input tells them apart. In the register window the destination index is taken from byte-address bits [9:4]. In the frame-data window every completed word goes to one fixed index, set by a parameter, whatever the address. Both windows feed the same staging buffer. Only full 32-bit writes are accepted. Reads are answered with zero data and flagged as unsupported.

Top module: `cfgb_bcast`

## Requirements
- R1: Reset clears staging lanes 0 to 2 to zero and drives `pkt_valid`, `rd_ack` and `rd_err` low. A lane-3 write as the first write after reset therefore produces a packet whose lanes 0 to 2 are zero.
- R2: A full write to lane 0, 1 or 2 updates only that staging lane. `pkt_valid` stays all-zero in the following cycle.
- R3: A full write to lane 3 (word-address bits [1:0] = 3) issues a packet in the next cycle. Data bits [31:0], [63:32] and [95:64] are staged lanes 0, 1 and 2. Bits [127:96] are the lane-3 write data. `pkt_valid` is high for that one cycle only.
- R4: For a register-window completion (`win_sel` = 0), `pkt_idx` equals word-address bits [7:2], which are byte-address bits [9:4].
- R5: For a frame-data-window completion (`win_sel` = 1), `pkt_idx` equals parameter `FRAME_IDX` for every address.
- R6: In the packet cycle, `pkt_valid` equals the 15-bit `tgt_en` mask. Bit n goes to port n, and all enabled ports pulse in the same clock.
- R7: A write whose byte strobes `wr_be` are not all ones is ignored. It changes no staging lane and produces no packet.
- R8: A read (`rd_en`) is answered one cycle later with `rd_ack` and `rd_err` both high and `rd_data` zero. A read changes no staging lane.
- R9: Both windows share one staging buffer. A word whose lanes come from mixed windows takes the index of the window that writes lane 3.
- R10: The lane-3 write is not staged, and staging lanes keep their values after a packet. A second lane-3 write with no lane 0 to 2 writes in between reuses the same lanes 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| win_sel | input | 1 | 0 = register window, 1 = frame-data window |
| wr_word | input | 8 | Word address (byte-address bits [9:2]) |
| wr_be | input | 4 | Byte strobes; only 4'hF is accepted |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_ack | output | 1 | Read answered, one cycle after `rd_en` |
| rd_err | output | 1 | Read flagged as unsupported |
| rd_data | output | 32 | Read data, always zero |
| tgt_en | input | 15 | Per-port enable mask |
| pkt_valid | output | 15 | Per-port packet valid pulse |
| pkt_idx | output | 6 | Packet register index |
| pkt_data | output | 128 | Packet data, lane 0 in bits [31:0] |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. A completed word appears on `pkt_valid`, `pkt_idx` and `pkt_data` after the lane-3 write edge. A read is answered on `rd_ack` and `rd_err` after the read edge. A lane 0 to 2 write or an ignored write shows no packet in that same next cycle. The bench drives inputs on the falling edge, lets one rising edge sample them, and checks the outputs at the next falling edge. Staging contents cannot be seen directly, so the bench reads them through the lanes of the next packet.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 32;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int LSEL_W  = $clog2(LANES);
    localparam int IDX_W   = 6;
    localparam int NPORT   = 15;
    localparam int WADDR_W = LSEL_W + IDX_W;
    localparam int STG_W   = (LANES - 1) * LANE_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } cfgb_pkt_t;

    typedef struct packed {
        logic              fire;
        logic [LANES-2:0]  stage_we;
        logic [IDX_W-1:0]  idx;
    } cfgb_dec_t;

    function automatic logic full_word(input logic [LANE_W/8-1:0] be);
        return &be;
    endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter logic [IDX_W-1:0] FRAME_IDX = 6'd1
) (
    input  logic               wr_en,
    input  logic               win_sel,
    input  logic [WADDR_W-1:0] wr_word,
    input  logic [LANE_W/8-1:0] wr_be,
    output cfgb_dec_t          dec
);
    logic              ok;
    logic [LSEL_W-1:0] lane;

    always_comb begin
        ok   = wr_en && full_word(wr_be);
        lane = wr_word[LSEL_W-1:0];
        dec.fire = ok && (lane == LSEL_W'(LANES - 1));
        dec.idx  = win_sel ? FRAME_IDX : wr_word[WADDR_W-1:LSEL_W];
        for (int i = 0; i < LANES - 1; i++) begin
            dec.stage_we[i] = ok && (lane == LSEL_W'(i));
        end
    end
endmodule

// File: rtl/cfgb_stage.sv
module cfgb_stage
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-2:0]  we,
    input  logic [LANE_W-1:0] wdata,
    output logic [STG_W-1:0]  stage
);
    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        logic [LANE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)        q <= '0;
            else if (we[g]) q <= wdata;
        end
        assign stage[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/cfgb_fanout.sv
module cfgb_fanout
    import cfgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  cfgb_pkt_t        pkt_in,
    input  logic [NPORT-1:0] tgt_en,
    output logic [NPORT-1:0] pkt_valid,
    output cfgb_pkt_t        pkt_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid <= '0;
            pkt_out   <= '0;
        end else begin
            pkt_valid <= fire ? tgt_en : '0;
            if (fire) pkt_out <= pkt_in;
        end
    end
endmodule

// File: rtl/cfgb_bcast.sv
module cfgb_bcast
    import cfgb_pkg::*;
#(
    parameter logic [IDX_W-1:0] FRAME_IDX = 6'd1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                win_sel,
    input  logic [WADDR_W-1:0]  wr_word,
    input  logic [LANE_W/8-1:0] wr_be,
    input  logic [LANE_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic                rd_ack,
    output logic                rd_err,
    output logic [LANE_W-1:0]   rd_data,
    input  logic [NPORT-1:0]    tgt_en,
    output logic [NPORT-1:0]    pkt_valid,
    output logic [IDX_W-1:0]    pkt_idx,
    output logic [WORD_W-1:0]   pkt_data
);
    cfgb_dec_t  dec;
    logic [STG_W-1:0] stage;
    cfgb_pkt_t  pkt_next;
    cfgb_pkt_t  pkt_q;

    cfgb_decode #(.FRAME_IDX(FRAME_IDX)) u_dec (
        .wr_en(wr_en), .win_sel(win_sel), .wr_word(wr_word),
        .wr_be(wr_be), .dec(dec)
    );

    cfgb_stage u_stage (
        .clk(clk), .rst(rst), .we(dec.stage_we), .wdata(wr_data), .stage(stage)
    );

    always_comb begin
        pkt_next.idx  = dec.idx;
        pkt_next.data = {wr_data, stage};
    end

    cfgb_fanout u_fan (
        .clk(clk), .rst(rst), .fire(dec.fire), .pkt_in(pkt_next),
        .tgt_en(tgt_en), .pkt_valid(pkt_valid), .pkt_out(pkt_q)
    );

    assign pkt_idx  = pkt_q.idx;
    assign pkt_data = pkt_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            rd_ack <= rd_en;
            rd_err <= rd_en;
        end
    end
    assign rd_data = '0;
endmodule

// File: rtl/cfgb_bcast_chk.sv
module cfgb_bcast_chk
    import cfgb_pkg::*;
#(
    parameter logic [IDX_W-1:0] FRAME_IDX = 6'd1
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                win_sel,
    input logic [WADDR_W-1:0]  wr_word,
    input logic [LANE_W/8-1:0] wr_be,
    input logic [LANE_W-1:0]   wr_data,
    input logic                rd_en,
    input logic                rd_ack,
    input logic                rd_err,
    input logic [NPORT-1:0]    tgt_en,
    input logic [NPORT-1:0]    pkt_valid,
    input logic [IDX_W-1:0]    pkt_idx,
    input logic [WORD_W-1:0]   pkt_data
);
    logic done;
    assign done = wr_en && (wr_be == 4'hF) && (wr_word[1:0] == 2'd3);

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !done |=> (pkt_valid == '0));
    p_top_lane_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> (pkt_data[WORD_W-1 -: LANE_W] == $past(wr_data)));
    p_reg_idx_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !win_sel) |=> (pkt_idx == $past(wr_word[7:2])));
    p_frame_idx_r5: assert property (@(posedge clk) disable iff (rst)
        (done && win_sel) |=> (pkt_idx == FRAME_IDX));
    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (pkt_valid == $past(tgt_en)));
    p_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_ack && rd_err));
    p_no_read_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_ack);
endmodule

bind cfgb_bcast cfgb_bcast_chk #(.FRAME_IDX(FRAME_IDX)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .win_sel(win_sel), .wr_word(wr_word),
    .wr_be(wr_be), .wr_data(wr_data), .rd_en(rd_en), .rd_ack(rd_ack),
    .rd_err(rd_err), .tgt_en(tgt_en), .pkt_valid(pkt_valid),
    .pkt_idx(pkt_idx), .pkt_data(pkt_data)
);

// File: tb/cfgb_bcast_tb.sv
module cfgb_bcast_tb;
    localparam logic [5:0] FIDX = 6'd1;

    logic         clk = 0;
    logic         rst;
    logic         wr_en = 0, win_sel = 0, rd_en = 0;
    logic [7:0]   wr_word = 0;
    logic [3:0]   wr_be = 0;
    logic [31:0]  wr_data = 0;
    logic         rd_ack, rd_err;
    logic [31:0]  rd_data;
    logic [14:0]  tgt_en = 15'h7FFF;
    logic [14:0]  pkt_valid;
    logic [5:0]   pkt_idx;
    logic [127:0] pkt_data;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [31:0] sm [3];

    always #10 clk = ~clk;

    cfgb_bcast #(.FRAME_IDX(FIDX)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .win_sel(win_sel), .wr_word(wr_word),
        .wr_be(wr_be), .wr_data(wr_data), .rd_en(rd_en), .rd_ack(rd_ack),
        .rd_err(rd_err), .rd_data(rd_data), .tgt_en(tgt_en),
        .pkt_valid(pkt_valid), .pkt_idx(pkt_idx), .pkt_data(pkt_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access: drive on falling edge, sample after one rising edge
    task automatic wr(input bit win, input logic [7:0] word, input logic [3:0] be,
                      input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; win_sel = win; wr_word = word; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (be == 4'hF && word[1:0] != 2'd3) sm[word[1:0]] = d;
    endtask

    task automatic expect_pkt(input string req, input logic [5:0] idx,
                              input logic [31:0] top);
        logic [127:0] e;
        e = {top, sm[2], sm[1], sm[0]};
        chk(pkt_valid == tgt_en, {req, " valid"}, 128'(pkt_valid), 128'(tgt_en));
        chk(pkt_idx == idx, {req, " idx"}, 128'(pkt_idx), 128'(idx));
        chk(pkt_data == e, {req, " data"}, pkt_data, e);
    endtask

    task automatic expect_none(input string req);
        chk(pkt_valid == 0, req, 128'(pkt_valid), 128'(0));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) sm[i] = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(pkt_valid == 0 && !rd_ack && !rd_err, "R1 reset outputs",
            {rd_ack, rd_err, pkt_valid}, 0);
        wr(0, {6'd5, 2'd3}, 4'hF, 32'hA5A5_0001);
        expect_pkt("R1 cleared lanes", 6'd5, 32'hA5A5_0001);
        // R4/R3/R2/R6: sweep all register indices with varying masks
        for (int idx = 0; idx < 64; idx++) begin
            tgt_en = 15'((idx * 32'h1F3) ^ (idx << 7));
            for (int l = 0; l < 3; l++) begin
                wr(0, {6'(idx), 2'(l)}, 4'hF, (idx * 32'h0101_0101) ^ (l << 28) ^ 32'h13);
                expect_none("R2 partial lane");
            end
            wr(0, {6'(idx), 2'd3}, 4'hF, ~(idx * 32'h0003_0005));
            expect_pkt("R4 R3 R6 reg window", 6'(idx), ~(idx * 32'h0003_0005));
        end
        // R5: frame window, index fixed for any address
        tgt_en = 15'h7FFF;
        for (int a = 0; a < 64; a++) begin
            wr(1, {6'(a), 2'(a % 3)}, 4'hF, a * 32'h0777_1001);
            expect_none("R2 frame partial");
            wr(1, {6'(63 - a), 2'd3}, 4'hF, a * 32'h0000_F00D);
            expect_pkt("R5 frame window", FIDX, a * 32'h0000_F00D);
        end
        // R7: partial strobes ignored
        for (int b = 0; b < 15; b++) begin
            wr(0, {6'd2, 2'(b % 3)}, 4'(b), 32'hDEAD_0000 | b);
            expect_none("R7 partial strobe lane");
            wr(0, {6'd2, 2'd3}, 4'(b), 32'hBEEF_0000 | b);
            expect_none("R7 partial strobe lane3");
        end
        wr(0, {6'd2, 2'd3}, 4'hF, 32'h7777_7777);
        expect_pkt("R7 staging untouched", 6'd2, 32'h7777_7777);
        // R8: reads
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        chk(rd_ack && rd_err && rd_data == 0, "R8 read response",
            {rd_ack, rd_err, rd_data}, {2'b11, 32'h0});
        expect_none("R8 read no packet");
        @(negedge clk);
        chk(!rd_ack, "R8 ack single cycle", 128'(rd_ack), 0);
        wr(0, {6'd3, 2'd3}, 4'hF, 32'h0000_8888);
        expect_pkt("R8 staging untouched", 6'd3, 32'h0000_8888);
        // R9: mixed windows
        wr(0, {6'd9, 2'd0}, 4'hF, 32'h1111_0000);
        wr(1, {6'd0, 2'd1}, 4'hF, 32'h2222_0000);
        wr(1, {6'd0, 2'd2}, 4'hF, 32'h3333_0000);
        wr(0, {6'd9, 2'd3}, 4'hF, 32'h4444_0000);
        expect_pkt("R9 reg completes", 6'd9, 32'h4444_0000);
        wr(0, {6'd40, 2'd1}, 4'hF, 32'h5555_0000);
        wr(1, {6'd40, 2'd3}, 4'hF, 32'h6666_0000);
        expect_pkt("R9 frame completes", FIDX, 32'h6666_0000);
        // R10: lane 3 not staged; lanes persist
        wr(0, {6'd12, 2'd3}, 4'hF, 32'hAAAA_0001);
        expect_pkt("R10 first", 6'd12, 32'hAAAA_0001);
        wr(0, {6'd13, 2'd3}, 4'hF, 32'hBBBB_0002);
        expect_pkt("R10 second", 6'd13, 32'hBBBB_0002);
        @(negedge clk);
        expect_none("R3 single cycle pulse");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule